// File: doc/BRIEF.md
# Dual-Clock DDR Output Register Pair

This block is the last register stage before an output pad. It turns two single-rate streams into one double-data-rate stream. It has two paths of the same shape. The data path drives the value sent to the pad. The three-state path drives the enable that decides whether the pad is driven. Each path has two registers:

- the rising register, clocked by `clk_rise`;
- the falling register, clocked by `clk_fall`, which the system supplies as the exact inverse of `clk_rise`.

A level-selected multiplexer shows the rising register while `clk_rise` is high and the falling register while it is low. Each captured word is therefore visible for half a period, and the output carries two words per period, in the order they were captured.

The two paths share both clocks, the synchronous active-low reset and the forcing pair (`init_req`, `init_flip`). Each path has its own clock enable. The forcing value is set by the `INIT_VAL` parameter, and the `ASYNC_INIT` parameter chooses whether forcing acts at the clock edge or at once. Both settings apply the same way to every register in the block.

Top module: `ddr_oreg_pair`

## Requirements
- R1: While `rst_n` is low and neither forcing input is high, each register loads all zeros at its next clock edge, so both outputs read 0 in both half periods.
- R2: When the data enable is high and no forcing or reset is active, `dat_ddr` shows the `d_rise` word captured at the latest rising edge of `clk_rise` while `clk_rise` is high, and the `d_fall` word captured at the latest rising edge of `clk_fall` while `clk_rise` is low. The resulting sequence is d_rise, d_fall, d_rise, d_fall.
- R3: The three-state path follows the same rule as R2 on `tri_ddr`, with `t_rise` and `t_fall` and the three-state enable.
- R4: While `dat_en` is low, both data registers keep their values whatever `d_rise` and `d_fall` do, and the three-state path is not affected.
- R5: While `tri_en` is low, both three-state registers keep their values, and the data path is not affected.
- R6: With `init_req` high and `init_flip` low, every register in both paths loads the forcing value (default 1, giving all ones). This happens whatever the enables and the reset are doing.
- R7: With `init_flip` high and `init_req` low, every register loads the inverse of the forcing value (default result: all zeros).
- R8: With both forcing inputs high, every register loads all zeros.
- R9: Forcing takes priority over `rst_n`: if forcing and reset are both active, the forcing result of R6 to R8 is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rise | input | 1 | Clock of the rising registers; also selects the output half |
| clk_fall | input | 1 | Clock of the falling registers; the inverse of clk_rise |
| rst_n | input | 1 | Synchronous active-low reset to zero |
| d_rise | input | W | Data word shown while clk_rise is high |
| d_fall | input | W | Data word shown while clk_rise is low |
| t_rise | input | W | Three-state control shown while clk_rise is high |
| t_fall | input | W | Three-state control shown while clk_rise is low |
| dat_en | input | 1 | Clock enable of both data registers |
| tri_en | input | 1 | Clock enable of both three-state registers |
| init_req | input | 1 | Forces every register to INIT_VAL |
| init_flip | input | 1 | Forces every register to the inverse of INIT_VAL |
| dat_ddr | output | W | Double-rate data output |
| tri_ddr | output | W | Double-rate three-state control output |

## Verification
The bench compares each half period of both outputs with a behavioural model.

- **Half and register swap.** It changes the words in every period, so a design that swapped the halves or wired the falling register to the rising clock would show a stale or misordered word.
- **Enable held low.** It drives new inputs while one enable is low. A design that shared the two enables, or ignored them, would let the held path move.
- **Each forcing input alone.** It applies each forcing input on its own with the enables low. A design that gated forcing with the enable would fail R6, and one that reversed the polarities would fail R7.
- **Both forcing inputs, and forcing against reset.** It applies both forcing inputs together, and forcing while reset is active. A design that gave the set side priority would output ones when both are high, against R8. A design that let reset win would output zeros when forcing with the set value, against R9.

// File: rtl/ddr_oreg_pkg.sv
// Package: shared helpers of the dual-clock DDR output register pair.
// Assumes: forcing controls are active high; INIT_VAL is one bit,
// replicated across the word by each user.
package ddr_oreg_pkg;

    // Forcing class decoded from the two forcing inputs
    typedef enum logic [1:0] {
        FRC_NONE = 2'd0,
        FRC_SET  = 2'd1,
        FRC_INV  = 2'd2,
        FRC_ZERO = 2'd3
    } frc_kind_e;

    // Decode the forcing pair into a class
    function automatic frc_kind_e frc_decode(input logic req, input logic flip);
        frc_kind_e k;
        if (req && flip)   k = FRC_ZERO;
        else if (req)      k = FRC_SET;
        else if (flip)     k = FRC_INV;
        else               k = FRC_NONE;
        return k;
    endfunction

    // Bit loaded by a forcing class
    function automatic logic frc_level(input frc_kind_e k, input logic init_val);
        logic b;
        case (k)
            FRC_SET:  b = init_val;
            FRC_INV:  b = ~init_val;
            default:  b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ddr_store_cell.sv
// Module: one storage register of a DDR output path.
// Does:   loads d on the rising edge of clk when ce is high. Forcing
//         beats the reset, and the reset beats the enable.
// Assumes: the reset is synchronous and active low; ASYNC_INIT picks
//          whether forcing acts at the clock edge (0) or at once (1).
module ddr_store_cell
    import ddr_oreg_pkg::*;
#(
    parameter int   W          = 4,
    parameter logic INIT_VAL   = 1'b1,
    parameter bit   ASYNC_INIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         init_req,
    input  logic         init_flip,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    frc_kind_e    kind;
    logic [W-1:0] frc_word;
    logic         frc_any;

    // Decode the forcing request and build the word it loads
    always_comb begin
        kind     = frc_decode(init_req, init_flip);
        frc_word = {W{frc_level(kind, INIT_VAL)}};
        frc_any  = (kind != FRC_NONE);
    end

    generate
        if (ASYNC_INIT) begin : g_async
            // Register whose forcing acts at once, without the clock
            always_ff @(posedge clk or posedge frc_any) begin
                if (frc_any)     q <= frc_word;
                else if (!rst_n) q <= '0;
                else if (ce)     q <= d;
            end
        end else begin : g_sync
            // Register whose forcing acts at the clock edge
            always_ff @(posedge clk) begin
                if (frc_any)     q <= frc_word;
                else if (!rst_n) q <= '0;
                else if (ce)     q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/ddr_out_path.sv
// Module: one DDR output path (a rising register, a falling register and
//         a level-selected multiplexer).
// Assumes: clk_fall is the inverse of clk_rise. The rising register's
//          value is shown while clk_rise is high, the falling one's
//          while it is low.
module ddr_out_path #(
    parameter int   W          = 4,
    parameter logic INIT_VAL   = 1'b1,
    parameter bit   ASYNC_INIT = 1'b0
) (
    input  logic         clk_rise,
    input  logic         clk_fall,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         init_req,
    input  logic         init_flip,
    input  logic [W-1:0] d_rise,
    input  logic [W-1:0] d_fall,
    output logic [W-1:0] q_rise,
    output logic [W-1:0] q_fall,
    output logic [W-1:0] ddr_out
);

    ddr_store_cell #(.W(W), .INIT_VAL(INIT_VAL), .ASYNC_INIT(ASYNC_INIT)) u_rise (
        .clk       (clk_rise),
        .rst_n     (rst_n),
        .ce        (ce),
        .init_req  (init_req),
        .init_flip (init_flip),
        .d         (d_rise),
        .q         (q_rise)
    );

    ddr_store_cell #(.W(W), .INIT_VAL(INIT_VAL), .ASYNC_INIT(ASYNC_INIT)) u_fall (
        .clk       (clk_fall),
        .rst_n     (rst_n),
        .ce        (ce),
        .init_req  (init_req),
        .init_flip (init_flip),
        .d         (d_fall),
        .q         (q_fall)
    );

    // Select the register that owns the current half period
    always_comb begin
        ddr_out = clk_rise ? q_rise : q_fall;
    end

endmodule

// File: rtl/ddr_oreg_pair.sv
// Module: top of the dual-clock DDR output register pair.
// Does:   serializes a data pair and a three-state pair onto two
//         double-rate outputs. The two paths share the clocks, the reset
//         and the forcing controls, and each has its own enable.
// Assumes: clk_fall is the inverse of clk_rise; rst_n is synchronous.
module ddr_oreg_pair #(
    parameter int   W          = 4,
    parameter logic INIT_VAL   = 1'b1,
    parameter bit   ASYNC_INIT = 1'b0
) (
    input  logic         clk_rise,
    input  logic         clk_fall,
    input  logic         rst_n,
    input  logic [W-1:0] d_rise,
    input  logic [W-1:0] d_fall,
    input  logic [W-1:0] t_rise,
    input  logic [W-1:0] t_fall,
    input  logic         dat_en,
    input  logic         tri_en,
    input  logic         init_req,
    input  logic         init_flip,
    output logic [W-1:0] dat_ddr,
    output logic [W-1:0] tri_ddr
);

    localparam int NPATH = 2;
    localparam int P_DAT = 0;
    localparam int P_TRI = 1;

    logic [W-1:0] d_in_rise [NPATH];
    logic [W-1:0] d_in_fall [NPATH];
    logic [W-1:0] q_r       [NPATH];
    logic [W-1:0] q_f       [NPATH];
    logic [W-1:0] ddr_o     [NPATH];
    logic         path_ce   [NPATH];

    logic [W-1:0] dat_q_rise, dat_q_fall, tri_q_rise, tri_q_fall;

    // Route each path's inputs and enable into the path arrays
    always_comb begin
        d_in_rise[P_DAT] = d_rise;
        d_in_fall[P_DAT] = d_fall;
        path_ce[P_DAT]   = dat_en;
        d_in_rise[P_TRI] = t_rise;
        d_in_fall[P_TRI] = t_fall;
        path_ce[P_TRI]   = tri_en;
    end

    generate
        for (genvar p = 0; p < NPATH; p++) begin : g_path
            ddr_out_path #(.W(W), .INIT_VAL(INIT_VAL), .ASYNC_INIT(ASYNC_INIT)) u_path (
                .clk_rise  (clk_rise),
                .clk_fall  (clk_fall),
                .rst_n     (rst_n),
                .ce        (path_ce[p]),
                .init_req  (init_req),
                .init_flip (init_flip),
                .d_rise    (d_in_rise[p]),
                .d_fall    (d_in_fall[p]),
                .q_rise    (q_r[p]),
                .q_fall    (q_f[p]),
                .ddr_out   (ddr_o[p])
            );
        end
    endgenerate

    // Expose the path results under readable names
    always_comb begin
        dat_ddr    = ddr_o[P_DAT];
        tri_ddr    = ddr_o[P_TRI];
        dat_q_rise = q_r[P_DAT];
        dat_q_fall = q_f[P_DAT];
        tri_q_rise = q_r[P_TRI];
        tri_q_fall = q_f[P_TRI];
    end

endmodule

// File: rtl/ddr_oreg_pair_chk.sv
// Module: assertion checker for ddr_oreg_pair, attached with bind.
// Assumes: forcing is synchronous (the default), so register values are
//          defined by the state at the previous edge of their own clock.
module ddr_oreg_pair_chk #(
    parameter int   W        = 4,
    parameter logic INIT_VAL = 1'b1
) (
    input logic         clk_rise,
    input logic         clk_fall,
    input logic         rst_n,
    input logic [W-1:0] d_rise,
    input logic [W-1:0] d_fall,
    input logic [W-1:0] t_rise,
    input logic [W-1:0] t_fall,
    input logic         dat_en,
    input logic         tri_en,
    input logic         init_req,
    input logic         init_flip,
    input logic [W-1:0] dat_q_rise,
    input logic [W-1:0] dat_q_fall,
    input logic [W-1:0] tri_q_rise,
    input logic [W-1:0] tri_q_fall
);

    // Rising data register loads d_rise when enabled and not forced
    assert_dat_rise_load_R2: assert property (@(posedge clk_rise) disable iff (!rst_n)
        (!init_req && !init_flip && dat_en) |=> (dat_q_rise == $past(d_rise)));

    // Falling data register loads d_fall on its own clock
    assert_dat_fall_load_R2: assert property (@(posedge clk_fall) disable iff (!rst_n)
        (!init_req && !init_flip && dat_en) |=> (dat_q_fall == $past(d_fall)));

    // Rising three-state register loads t_rise
    assert_tri_rise_load_R3: assert property (@(posedge clk_rise) disable iff (!rst_n)
        (!init_req && !init_flip && tri_en) |=> (tri_q_rise == $past(t_rise)));

    // Falling three-state register loads t_fall
    assert_tri_fall_load_R3: assert property (@(posedge clk_fall) disable iff (!rst_n)
        (!init_req && !init_flip && tri_en) |=> (tri_q_fall == $past(t_fall)));

    // Data registers hold while their enable is low
    assert_dat_hold_R4: assert property (@(posedge clk_rise) disable iff (!rst_n)
        (!init_req && !init_flip && !dat_en) |=> $stable(dat_q_rise));

    // Three-state registers hold while their enable is low
    assert_tri_hold_R5: assert property (@(posedge clk_fall) disable iff (!rst_n)
        (!init_req && !init_flip && !tri_en) |=> $stable(tri_q_fall));

    // Forcing with init_req alone loads INIT_VAL
    assert_force_set_R6: assert property (@(posedge clk_rise) disable iff (!rst_n)
        (init_req && !init_flip) |=> (tri_q_rise == {W{INIT_VAL}}));

    // Forcing with init_flip alone loads the inverse of INIT_VAL
    assert_force_inv_R7: assert property (@(posedge clk_fall) disable iff (!rst_n)
        (!init_req && init_flip) |=> (dat_q_fall == {W{~INIT_VAL}}));

    // Both forcing inputs load zero
    assert_force_zero_R8: assert property (@(posedge clk_rise) disable iff (!rst_n)
        (init_req && init_flip) |=> (dat_q_rise == '0));

endmodule

bind ddr_oreg_pair ddr_oreg_pair_chk #(.W(W), .INIT_VAL(INIT_VAL)) u_chk (
    .clk_rise   (clk_rise),
    .clk_fall   (clk_fall),
    .rst_n      (rst_n),
    .d_rise     (d_rise),
    .d_fall     (d_fall),
    .t_rise     (t_rise),
    .t_fall     (t_fall),
    .dat_en     (dat_en),
    .tri_en     (tri_en),
    .init_req   (init_req),
    .init_flip  (init_flip),
    .dat_q_rise (dat_q_rise),
    .dat_q_fall (dat_q_fall),
    .tri_q_rise (tri_q_rise),
    .tri_q_fall (tri_q_fall)
);

// File: tb/tb_ddr_oreg_pair.sv
// Bench: behavioural model of the four registers, compared in every half
// period of a 125 MHz clock pair.
module tb_ddr_oreg_pair;

    localparam int   W    = 4;
    localparam logic IVAL = 1'b1;

    logic         clk_rise  = 1'b0;
    logic         clk_fall  = 1'b1;
    logic         rst_n     = 1'b0;
    logic [W-1:0] d_rise    = '0;
    logic [W-1:0] d_fall    = '0;
    logic [W-1:0] t_rise    = '0;
    logic [W-1:0] t_fall    = '0;
    logic         dat_en    = 1'b0;
    logic         tri_en    = 1'b0;
    logic         init_req  = 1'b0;
    logic         init_flip = 1'b0;
    logic [W-1:0] dat_ddr;
    logic [W-1:0] tri_ddr;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    armed    = 1'b0;
    string tag_d    = "R1";
    string tag_t    = "R1";

    // Model state: expected register contents
    int exp_dr = 0, exp_df = 0, exp_tr = 0, exp_tf = 0;

    ddr_oreg_pair #(.W(W), .INIT_VAL(IVAL), .ASYNC_INIT(1'b0)) dut (
        .clk_rise  (clk_rise),
        .clk_fall  (clk_fall),
        .rst_n     (rst_n),
        .d_rise    (d_rise),
        .d_fall    (d_fall),
        .t_rise    (t_rise),
        .t_fall    (t_fall),
        .dat_en    (dat_en),
        .tri_en    (tri_en),
        .init_req  (init_req),
        .init_flip (init_flip),
        .dat_ddr   (dat_ddr),
        .tri_ddr   (tri_ddr)
    );

    // 125 MHz complementary clocks
    always #4 begin
        clk_rise = ~clk_rise;
        clk_fall = ~clk_fall;
    end

    // Expected next value of one register from the requirement rules
    function automatic int next_val(int cur, int din, bit en);
        int all1 = (1 << W) - 1;
        if (init_req && init_flip) return 0;                 // R8
        if (init_req)              return IVAL ? all1 : 0;   // R6, R9
        if (init_flip)             return IVAL ? 0 : all1;   // R7
        if (!rst_n)                return 0;                 // R1
        if (en)                    return din;               // R2, R3
        return cur;                                          // R4, R5
    endfunction

    always @(posedge clk_rise) begin
        exp_dr <= next_val(exp_dr, int'(d_rise), dat_en);
        exp_tr <= next_val(exp_tr, int'(t_rise), tri_en);
    end

    always @(posedge clk_fall) begin
        exp_df <= next_val(exp_df, int'(d_fall), dat_en);
        exp_tf <= next_val(exp_tf, int'(t_fall), tri_en);
    end

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
        end
    endtask

    // Compare the shown half periods against the model
    always @(posedge clk_rise) begin
        #2;
        if (armed) begin
            check(tag_d, "dat_ddr high half", int'(dat_ddr), exp_dr);
            check(tag_t, "tri_ddr high half", int'(tri_ddr), exp_tr);
        end
    end

    always @(posedge clk_fall) begin
        #2;
        if (armed) begin
            check(tag_d, "dat_ddr low half", int'(dat_ddr), exp_df);
            check(tag_t, "tri_ddr low half", int'(tri_ddr), exp_tf);
        end
    end

    // One period of stimulus: change the inputs 1 ns after the rising edge
    task automatic step(bit rn, bit de, bit te, bit rq, bit fl);
        rst_n     = rn;
        dat_en    = de;
        tri_en    = te;
        init_req  = rq;
        init_flip = fl;
        d_rise    = W'($urandom);
        d_fall    = W'($urandom);
        t_rise    = W'($urandom);
        t_fall    = W'($urandom);
        @(posedge clk_rise);
        #1;
    endtask

    initial begin
        @(posedge clk_rise);
        #1;
        armed = 1'b1;
        // R1: reset loads zero
        tag_d = "R1"; tag_t = "R1";
        repeat (3) step(0, 1, 1, 0, 0);
        // R2 / R3: both paths stream
        tag_d = "R2"; tag_t = "R3";
        repeat (8) step(1, 1, 1, 0, 0);
        // R4: data held, three-state still streams
        tag_d = "R4"; tag_t = "R3";
        repeat (5) step(1, 0, 1, 0, 0);
        // R5: three-state held, data streams
        tag_d = "R2"; tag_t = "R5";
        repeat (5) step(1, 1, 0, 0, 0);
        // R6: set forcing beats low enables
        tag_d = "R6"; tag_t = "R6";
        repeat (3) step(1, 0, 0, 1, 0);
        // R7: inverse forcing
        tag_d = "R7"; tag_t = "R7";
        repeat (3) step(1, 0, 0, 0, 1);
        // R2 / R3: stream again to leave the forced state
        tag_d = "R2"; tag_t = "R3";
        repeat (3) step(1, 1, 1, 0, 0);
        // R8: both forcing inputs give zero
        tag_d = "R8"; tag_t = "R8";
        repeat (3) step(1, 1, 1, 1, 1);
        // R9: set forcing beats reset
        tag_d = "R9"; tag_t = "R9";
        repeat (3) step(0, 1, 1, 1, 0);
        // R1: reset again after a forced state
        tag_d = "R1"; tag_t = "R1";
        repeat (3) step(0, 1, 1, 0, 0);
        tag_d = "R2"; tag_t = "R3";
        repeat (6) step(1, 1, 1, 0, 0);
        armed = 1'b0;
        #10;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check
    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule